// File: doc/BRIEF.md
# Row-Constrained Stereo Feature Matcher

This block pairs corner features found in a rectified left image with corners found in the matching right image. Because the two images are rectified, a feature can only match a feature on the same row. The search along a row is therefore one-dimensional. Both feature lists sit in external register files with combinational read. Each list is sorted by row and then by column. The block walks through them in row order.

For every left feature, the block scores each eligible right feature on the same row. The score is the sum of absolute differences over a square patch of pixels around each corner. The patch pixels come from two small per-feature patch memories, which the block addresses by feature index and pixel index. The right feature with the lowest score is kept. It is reported only when that score is below a programmable threshold. Each accepted pair is presented on an output write port, which the consumer can hold off with a full flag. When the left list is used up, the block raises a done flag and reports how many pairs it wrote.

Top module: `stereo_row_matcher`

## Requirements
- R1: After reset and before any start pulse, `done` is 0, `out_valid` is 0 and `match_count` is 0.
- R2: A right feature is a candidate for a left feature only when its row coordinate equals the left row. The emitted `out_row` equals that shared row.
- R3: The score of a candidate is the sum of |left pixel - right pixel| over all WIN*WIN patch pixels. Patch pixel k (0 to WIN*WIN-1, raster order) of a feature is read at feature index `l_addr`/`r_addr` and pixel index `pix_sel` = k. The winning score appears on `out_score`.
- R4: A pair is emitted only when its score is strictly below `thresh`. A score equal to `thresh` is rejected.
- R5: For each left feature, only the candidate with the lowest score is kept. When scores tie, the candidate with the lower right column is kept.
- R6: A right feature whose column is greater than the left feature's column is never a candidate. This keeps the disparity non-negative.
- R7: At most one pair is emitted per left feature. Pairs are emitted in the order of the left list.
- R8: While `out_full` is 1, `out_valid` stays 0. A pending pair is emitted unchanged once `out_full` returns to 0.
- R9: After all `l_count` left features are processed, `done` goes to 1 and `match_count` equals the number of pairs emitted. Both hold until the next `start`. An empty list of either side ends with a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a matching pass (accepted when idle or done) |
| l_count | input | IDX_W+1 | Number of left features |
| r_count | input | IDX_W+1 | Number of right features |
| thresh | input | SCORE_W | Acceptance limit on the score (exclusive) |
| l_addr | output | IDX_W | Left feature and left patch index |
| l_row | input | ROW_W | Row of left feature at `l_addr` |
| l_col | input | COL_W | Column of left feature at `l_addr` |
| r_addr | output | IDX_W | Right feature and right patch index |
| r_row | input | ROW_W | Row of right feature at `r_addr` |
| r_col | input | COL_W | Column of right feature at `r_addr` |
| pix_sel | output | K_W | Pixel index inside the patch |
| l_pix | input | PIX_W | Left patch pixel |
| r_pix | input | PIX_W | Right patch pixel |
| out_full | input | 1 | Output buffer full, stalls emission |
| out_valid | output | 1 | Pair written this cycle |
| out_row | output | ROW_W | Row of the pair |
| out_lcol | output | COL_W | Left column |
| out_rcol | output | COL_W | Right column |
| out_score | output | SCORE_W | Score of the pair |
| done | output | 1 | Pass complete |
| match_count | output | IDX_W+1 | Pairs written in this pass |

## Verification
The assertions check four properties on every cycle. No pair leaves while the buffer is full. Every emitted score lies below the threshold and every emitted disparity is non-negative. Each emission raises the count by exactly one. A finished pass holds its count. The bench's own scenarios show the rest. These are the choice of the best candidate, the tie rule, and the exclusion of positive-disparity and other-row features. They also cover the exact score value, the strict threshold boundary, and the pass-level total against an arithmetic model. All of these are exercised over sweeps of generated feature lists, with and without back-pressure.

// File: rtl/stereo_row_matcher.sv
module stereo_row_matcher #(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  parameter int IDX_W = 6,
  parameter int WIN   = 5,
  parameter int PIX_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [IDX_W:0]                 l_count,
  input  logic [IDX_W:0]                 r_count,
  input  logic [PIX_W+$clog2(WIN*WIN)-1:0] thresh,
  output logic [IDX_W-1:0]               l_addr,
  input  logic [ROW_W-1:0]               l_row,
  input  logic [COL_W-1:0]               l_col,
  output logic [IDX_W-1:0]               r_addr,
  input  logic [ROW_W-1:0]               r_row,
  input  logic [COL_W-1:0]               r_col,
  output logic [$clog2(WIN*WIN)-1:0]     pix_sel,
  input  logic [PIX_W-1:0]               l_pix,
  input  logic [PIX_W-1:0]               r_pix,
  input  logic                           out_full,
  output logic                           out_valid,
  output logic [ROW_W-1:0]               out_row,
  output logic [COL_W-1:0]               out_lcol,
  output logic [COL_W-1:0]               out_rcol,
  output logic [PIX_W+$clog2(WIN*WIN)-1:0] out_score,
  output logic                           done,
  output logic [IDX_W:0]                 match_count
);
  localparam int NPIX    = WIN * WIN;
  localparam int K_W     = $clog2(NPIX);
  localparam int SCORE_W = PIX_W + $clog2(NPIX);
  localparam int CNT_W   = IDX_W + 1;

  typedef enum logic [3:0] {
    S_IDLE, S_LOAD, S_SKIP, S_CAND, S_SAD, S_SCORE, S_DECIDE, S_EMIT, S_DONE
  } state_t;

  state_t             state;
  logic [CNT_W-1:0]   li, r_ptr, rbase;
  logic [ROW_W-1:0]   cur_row;
  logic [COL_W-1:0]   cur_col, best_col;
  logic [SCORE_W-1:0] acc, best_score;
  logic               best_ok;
  logic [K_W-1:0]     k;
  logic [PIX_W-1:0]   absd;
  logic               r_end;

  assign l_addr  = li[IDX_W-1:0];
  assign r_addr  = r_ptr[IDX_W-1:0];
  assign pix_sel = k;
  assign absd    = (l_pix >= r_pix) ? (l_pix - r_pix) : (r_pix - l_pix);
  assign r_end   = (r_ptr == r_count);

  assign out_valid = (state == S_EMIT) && !out_full;
  assign out_row   = cur_row;
  assign out_lcol  = cur_col;
  assign out_rcol  = best_col;
  assign out_score = best_score;
  assign done      = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      li          <= '0;
      r_ptr       <= '0;
      rbase       <= '0;
      cur_row     <= '0;
      cur_col     <= '0;
      best_col    <= '0;
      best_score  <= '0;
      best_ok     <= 1'b0;
      acc         <= '0;
      k           <= '0;
      match_count <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE: begin
          if (start) begin
            li          <= '0;
            r_ptr       <= '0;
            rbase       <= '0;
            match_count <= '0;
            state       <= S_LOAD;
          end
        end
        S_LOAD: begin
          if (li == l_count) begin
            state <= S_DONE;
          end else begin
            cur_row <= l_row;
            cur_col <= l_col;
            best_ok <= 1'b0;
            state   <= S_SKIP;
          end
        end
        S_SKIP: begin
          if (!r_end && (r_row < cur_row)) begin
            r_ptr <= r_ptr + 1'b1;
            rbase <= r_ptr + 1'b1;
          end else begin
            state <= S_CAND;
          end
        end
        S_CAND: begin
          if (r_end || (r_row != cur_row) || (r_col > cur_col)) begin
            state <= S_DECIDE;
          end else begin
            k     <= '0;
            acc   <= '0;
            state <= S_SAD;
          end
        end
        S_SAD: begin
          acc <= acc + {{(SCORE_W-PIX_W){1'b0}}, absd};
          k   <= k + 1'b1;
          if (k == K_W'(NPIX - 1)) state <= S_SCORE;
        end
        S_SCORE: begin
          if (!best_ok || (acc < best_score)) begin
            best_ok    <= 1'b1;
            best_score <= acc;
            best_col   <= r_col;
          end
          r_ptr <= r_ptr + 1'b1;
          state <= S_CAND;
        end
        S_DECIDE: begin
          r_ptr <= rbase;
          if (best_ok && (best_score < thresh)) begin
            state <= S_EMIT;
          end else begin
            li    <= li + 1'b1;
            state <= S_LOAD;
          end
        end
        S_EMIT: begin
          if (!out_full) begin
            match_count <= match_count + 1'b1;
            li          <= li + 1'b1;
            state       <= S_LOAD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_no_emit_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_full |-> !out_valid);

  assert_pending_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EMIT && out_full) |=> (state == S_EMIT && $stable(out_rcol) && $stable(out_score)));

  assert_below_thresh_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_score < thresh));

  assert_nonneg_disp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_rcol <= out_lcol));

  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> (match_count == $past(match_count) + 1'b1));

  assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(match_count)));
endmodule

// File: tb/sim_stereo_row_matcher.sv
module sim_stereo_row_matcher;
  localparam int PERIOD = 10;
  localparam int NP = 25;

  logic clk = 0, rst_n = 0, start = 0, out_full = 0, stall_en = 0;
  logic [6:0] l_count = 0, r_count = 0;
  logic [12:0] thresh = 0;
  logic [5:0] l_addr, r_addr;
  logic [9:0] l_row, l_col, r_row, r_col;
  logic [4:0] pix_sel;
  logic [7:0] l_pix, r_pix;
  logic out_valid, done;
  logic [9:0] out_row, out_lcol, out_rcol;
  logic [12:0] out_score;
  logic [6:0] match_count;

  int lrow[64], lcol[64], rrow[64], rcol[64];
  int lp[64][NP], rp[64][NP];
  int exp_row[64], exp_l[64], exp_r[64], exp_s[64];
  int n_exp, got, checks, errors, scyc;

  always #(PERIOD/2) clk = ~clk;

  stereo_row_matcher u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .l_count(l_count), .r_count(r_count),
    .thresh(thresh), .l_addr(l_addr), .l_row(l_row), .l_col(l_col),
    .r_addr(r_addr), .r_row(r_row), .r_col(r_col), .pix_sel(pix_sel),
    .l_pix(l_pix), .r_pix(r_pix), .out_full(out_full), .out_valid(out_valid),
    .out_row(out_row), .out_lcol(out_lcol), .out_rcol(out_rcol),
    .out_score(out_score), .done(done), .match_count(match_count));

  always_comb begin
    l_row = 10'(lrow[l_addr]);
    l_col = 10'(lcol[l_addr]);
    r_row = 10'(rrow[r_addr]);
    r_col = 10'(rcol[r_addr]);
    l_pix = (pix_sel < 5'(NP)) ? 8'(lp[l_addr][pix_sel]) : 8'd0;
    r_pix = (pix_sel < 5'(NP)) ? 8'(rp[r_addr][pix_sel]) : 8'd0;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  initial forever begin
    @(posedge clk); #1;
    scyc++;
    out_full = stall_en && ((scyc % 5) < 2);
  end

  always @(negedge clk) begin
    if (out_valid) begin
      if (out_full) chk(0, "R8 emit while full", 1, 0);
      if (got >= n_exp) chk(0, "R7 extra pair", got + 1, n_exp);
      else begin
        chk(int'(out_row) == exp_row[got], "R2 row", int'(out_row), exp_row[got]);
        chk(int'(out_lcol) == exp_l[got], "R7 left column order", int'(out_lcol), exp_l[got]);
        chk(int'(out_rcol) == exp_r[got], "R5 R6 best right column", int'(out_rcol), exp_r[got]);
        chk(int'(out_score) == exp_s[got], "R3 R4 score", int'(out_score), exp_s[got]);
      end
      got++;
    end
  end

  function automatic int sad(input int i, input int j);
    int s = 0;
    for (int k = 0; k < NP; k++) s += (lp[i][k] > rp[j][k]) ? lp[i][k] - rp[j][k] : rp[j][k] - lp[i][k];
    return s;
  endfunction

  task automatic model(input int nl, input int nr, input int thr);
    n_exp = 0;
    for (int i = 0; i < nl; i++) begin
      int bs = -1, bc = 0;
      for (int j = 0; j < nr; j++) begin
        if (rrow[j] == lrow[i] && rcol[j] <= lcol[i]) begin
          int s = sad(i, j);
          if (bs < 0 || s < bs) begin bs = s; bc = rcol[j]; end
        end
      end
      if (bs >= 0 && bs < thr) begin
        exp_row[n_exp] = lrow[i]; exp_l[n_exp] = lcol[i];
        exp_r[n_exp] = bc; exp_s[n_exp] = bs; n_exp++;
      end
    end
  endtask

  task automatic gen(input int seed, input int nl, input int nr);
    for (int i = 0; i < nl; i++) begin
      lrow[i] = (i / 3) * 2;
      lcol[i] = 20 + (i % 3) * 30 + seed % 7;
      for (int k = 0; k < NP; k++) lp[i][k] = (seed * 53 + i * 29 + k * 17 + k * i * 7) % 256;
    end
    for (int j = 0; j < nr; j++) begin
      rrow[j] = (seed % 2 == 0) ? (j / 4) * 2 : j / 4;
      rcol[j] = 5 + (j % 4) * 22 + seed % 5;
      for (int k = 0; k < NP; k++) rp[j][k] = (seed * 53 + j * 31 + k * 17 + (k * j * 5) % 40) % 256;
    end
  endtask

  task automatic run(input int nl, input int nr, input int thr, input string tag);
    int w = 0;
    l_count = 7'(nl); r_count = 7'(nr); thresh = 13'(thr);
    model(nl, nr, thr);
    got = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (!done && w < 40000) begin @(negedge clk); w++; end
    chk(done == 1'b1, {"R9 done ", tag}, int'(done), 1);
    chk(int'(match_count) == n_exp, {"R9 count ", tag}, int'(match_count), n_exp);
    chk(got == n_exp, {"R7 pairs ", tag}, got, n_exp);
    repeat (3) @(negedge clk);
    chk(done && int'(match_count) == n_exp, {"R9 hold ", tag}, int'(match_count), n_exp);
  endtask

  task automatic manual_setup();
    lrow[0] = 5; lcol[0] = 20;
    rrow[0] = 3; rcol[0] = 1;
    rrow[1] = 5; rcol[1] = 10;
    rrow[2] = 5; rcol[2] = 15;
    rrow[3] = 5; rcol[3] = 25;
    for (int k = 0; k < NP; k++) begin
      lp[0][k] = 100; rp[0][k] = 100; rp[1][k] = 110; rp[2][k] = 90; rp[3][k] = 100;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    chk(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0; got = 0; n_exp = 0; scyc = 0;
    for (int i = 0; i < 64; i++) begin
      lrow[i] = 0; lcol[i] = 0; rrow[i] = 0; rcol[i] = 0;
      for (int k = 0; k < NP; k++) begin lp[i][k] = 0; rp[i][k] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!done && !out_valid && match_count == 0, "R1 reset state", int'(match_count), 0);

    for (int s = 1; s <= 6; s++) begin
      gen(s, 6 + s * 2, 8 + s * 2);
      stall_en = (s > 3);
      run(6 + s * 2, 8 + s * 2, (s % 2 == 1) ? 8191 : 2600 + s * 100, "sweep");
    end
    stall_en = 0;

    // R5 tie to lower column, R6 zero-score candidate at higher column excluded
    manual_setup();
    run(1, 4, 8191, "tie");
    chk(got == 1 && exp_r[0] == 10 && exp_s[0] == 250, "R5 tie model", exp_r[0], 10);

    // R4 score equal to limit rejected, one above accepted
    manual_setup();
    run(1, 4, 250, "thr_eq");
    chk(got == 0, "R4 equal rejected", got, 0);
    manual_setup();
    stall_en = 1;
    run(1, 4, 251, "thr_plus");
    chk(got == 1, "R4 above accepted", got, 1);
    stall_en = 0;

    // R2 no right feature on the left row
    manual_setup();
    lrow[0] = 4;
    run(1, 4, 8191, "norow");
    chk(got == 0, "R2 other rows ignored", got, 0);

    gen(7, 0, 10);
    run(0, 10, 8191, "empty_left");
    gen(8, 9, 0);
    run(9, 0, 8191, "empty_right");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule